// File: doc/BRIEF.md
# Phase-Modulated Numerically Controlled Oscillator Core

This block is the arithmetic heart of a direct digital synthesizer. A 32-bit phase register moves forward on every clock by a frequency word. An optional carry into its least significant bit adds one more step per cycle, which gives a finer frequency grid. A 12-bit phase offset is added to the top 12 bits of that register. The resulting phase indexes a folded quarter-wave sine table, and the block returns a signed 12-bit sine sample and a signed 12-bit cosine sample. The sine path and the cosine path each have their own offset.

Offsets are committed by a falling edge on a load strobe. A source select picks the origin of the offsets. In one setting, two externally held buffer values give separate offsets for the sine path and the cosine path. In the other setting, a direct parallel word is split over a 4-bit low field and an 8-bit high field, and the same value goes to both paths. The change reaches the outputs after a fixed twelve-clock pipeline. The frequency word is applied directly. Register files, modulation arithmetic and conversion to analog lie outside the block.

Top module: `nco_pm_core`

## Requirements
- R1: On every rising clock edge without reset, `acc_out` becomes `acc_out + freq_word + carry_in`, modulo 2^32.
- R2: `carry_in` = 1 raises the per-cycle step by exactly one. With `freq_word` = 32'hFFFF_FFFF and `carry_in` = 1, the accumulator does not move.
- R3: A synchronous active-high `rst` clears the accumulator and both phase offsets. Afterwards, with `freq_word` = 0 and no load, `sin_out` and `cos_out` hold the zero-phase samples (sine near 0, cosine near +2047).
- R4: An offset load needs `ph_load` sampled high at one edge and low at the next edge (E0). The source is sampled at edge E1 and committed at edge E2. A level held low, or held high, loads nothing.
- R5: With `ph_sel` = 1, the sine offset is `buf_sin_ph` and the cosine offset is `buf_cos_ph`. With `ph_sel` = 0, both offsets are `{dir_hi, dir_lo}`: `dir_hi` supplies bits 11..4 and `dir_lo` supplies bits 3..0. The buffer inputs are then ignored.
- R6: The sine path phase is p = `acc_out[31:20]` + sine offset, mod 4096. `sin_out` equals round(2047·sin(2π(p+0.5)/4096)) in two's complement, within 1 LSB. Neither output ever shows -2048.
- R7: With cosine path phase c, `cos_out` equals exactly the sine sample of c+1024. So `cos_out` == `sin_out` whenever the sine phase leads the cosine phase by 1024.
- R8: A new offset first appears at the outputs after edge E12, counting E0 as the edge that sees `ph_load` low. Through edge E11 the outputs still show the old offset.
- R9: The offset MSB is a half-turn: adding 2048 to an offset negates the sample exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| freq_word | input | 32 | Phase step added each cycle |
| carry_in | input | 1 | Extra carry into the accumulator LSB |
| ph_load | input | 1 | Offset load strobe, falling edge acts |
| ph_sel | input | 1 | 1: buffer offsets, 0: direct word |
| buf_sin_ph | input | 12 | Buffered sine-path offset |
| buf_cos_ph | input | 12 | Buffered cosine-path offset |
| dir_hi | input | 8 | Direct offset bits 11..4 |
| dir_lo | input | 4 | Direct offset bits 3..0 |
| acc_out | output | 32 | Phase accumulator value |
| sin_out | output | 12 | Signed sine sample |
| cos_out | output | 12 | Signed cosine sample |

## Verification
The commit of one offset can fall in the same cycle as the falling-edge detection of the next load. The bench provokes this with a strobe that goes high for a single cycle between two falls, and it changes the direct word between the two capture cycles. It judges the result by checking that the first value reaches the outputs after E12, and that the second value replaces it exactly two edges later without being lost or merged.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam int PH_W    = 12;
    localparam int AMP_W   = 12;
    localparam int QTR_W   = PH_W - 2;
    localparam int QTR_N   = 1 << QTR_W;
    localparam int AMP_MAX = (1 << (AMP_W - 1)) - 1;
    localparam int FRAC    = 28;
    // pi scaled by 2^FRAC
    localparam longint PI_FX = 64'sd843314857;

    typedef logic [PH_W-1:0]         phase_t;
    typedef logic signed [AMP_W-1:0] sample_t;
    typedef logic [AMP_W-2:0]        mag_t;

    typedef struct packed {
        phase_t sin_ph;
        phase_t cos_ph;
    } phase_pair_t;

    typedef enum logic {
        SRC_DIRECT = 1'b0,
        SRC_BUFFER = 1'b1
    } phase_src_e;

    // Magnitude of entry idx of a quarter-wave table sampled at half-step centres.
    // Fixed-point odd Taylor series, accurate well below one output LSB.
    function automatic int quarter_mag(int idx, int qtr_n, int amp);
        longint x;
        longint x2;
        longint term;
        longint sum;
        x    = ((2 * longint'(idx) + 1) * PI_FX) / (4 * longint'(qtr_n));
        x2   = (x * x) >>> FRAC;
        term = x;
        sum  = x;
        for (int k = 1; k <= 5; k++) begin
            term = -((term * x2) >>> FRAC) / longint'((2 * k) * (2 * k + 1));
            sum  = sum + term;
        end
        return int'((sum * longint'(amp) + (64'sd1 <<< (FRAC - 1))) >>> FRAC);
    endfunction

endpackage

// File: rtl/nco_accum.sv
module nco_accum #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] freq_word,
    input  logic             carry_in,
    output logic [ACC_W-1:0] acc_q
);

    localparam logic [ACC_W-2:0] CARRY_PAD = '0;

    logic run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            run_q <= 1'b0;
        end else begin
            acc_q <= acc_q + freq_word + {CARRY_PAD, carry_in};
            run_q <= 1'b1;
        end
    end

    // R1 / R2: step per cycle is the frequency word plus the carry
    a_r1_acc_step: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (acc_q == $past(acc_q) + $past(freq_word) + {CARRY_PAD, $past(carry_in)}));

endmodule

// File: rtl/nco_phase_load.sv
module nco_phase_load
    import nco_pkg::*;
#(
    parameter int DIR_LO_W = 4,
    localparam int DIR_HI_W = PH_W - DIR_LO_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ph_load,
    input  logic                ph_sel,
    input  phase_t              buf_sin_ph,
    input  phase_t              buf_cos_ph,
    input  logic [DIR_HI_W-1:0] dir_hi,
    input  logic [DIR_LO_W-1:0] dir_lo,
    output phase_pair_t         offs_q
);

    logic        ld_q;
    logic        fall_d;
    logic        cap_v;
    phase_t      direct_word;
    phase_pair_t src;
    phase_pair_t stage_q;

    assign direct_word = {dir_hi, dir_lo};

    always_comb begin
        if (phase_src_e'(ph_sel) == SRC_BUFFER) begin
            src.sin_ph = buf_sin_ph;
            src.cos_ph = buf_cos_ph;
        end else begin
            src.sin_ph = direct_word;
            src.cos_ph = direct_word;
        end
    end

    // edge E0 detects the fall, E1 samples the source, E2 commits it
    always_ff @(posedge clk) begin
        if (rst) begin
            ld_q    <= 1'b0;
            fall_d  <= 1'b0;
            cap_v   <= 1'b0;
            stage_q <= '0;
            offs_q  <= '0;
        end else begin
            ld_q   <= ph_load;
            fall_d <= ld_q & ~ph_load;
            cap_v  <= fall_d;
            if (fall_d) stage_q <= src;
            if (cap_v)  offs_q  <= stage_q;
        end
    end

    // R4: the staged value only moves one cycle after a detected fall
    a_r4_stage_hold: assert property (@(posedge clk) disable iff (rst)
        !fall_d |=> $stable(stage_q));

    // R4: the committed offsets only move one cycle after a capture
    a_r4_offs_hold: assert property (@(posedge clk) disable iff (rst)
        !cap_v |=> $stable(offs_q));

    // R5: direct source feeds one word to both paths
    a_r5_direct_shared: assert property (@(posedge clk) disable iff (rst)
        (fall_d && !ph_sel) |=> (stage_q.sin_ph == stage_q.cos_ph));

endmodule

// File: rtl/nco_sine_fold.sv
module nco_sine_fold
    import nco_pkg::*;
#(
    parameter bit QUAD_SHIFT = 1'b0
) (
    input  logic    clk,
    input  logic    rst,
    input  phase_t  phase_in,
    output sample_t sample_q
);

    localparam mag_t RST_MAG = mag_t'(quarter_mag(QUAD_SHIFT ? QTR_N - 1 : 0, QTR_N, AMP_MAX));

    mag_t                qtab [QTR_N];
    phase_t              ph;
    logic [1:0]          quad;
    logic [QTR_W-1:0]    idx;
    logic [QTR_W-1:0]    addr;
    mag_t                mag;
    sample_t             sample_d;

    for (genvar g = 0; g < QTR_N; g++) begin : g_tab
        assign qtab[g] = mag_t'(quarter_mag(g, QTR_N, AMP_MAX));
    end

    if (QUAD_SHIFT) begin : g_lead
        assign ph = phase_in + phase_t'(QTR_N);
    end else begin : g_plain
        assign ph = phase_in;
    end

    assign quad = ph[PH_W-1 -: 2];
    assign idx  = ph[QTR_W-1:0];
    assign addr = quad[0] ? ~idx : idx;
    assign mag  = qtab[addr];

    always_comb begin
        if (quad[1]) sample_d = -$signed({1'b0, mag});
        else         sample_d =  $signed({1'b0, mag});
    end

    always_ff @(posedge clk) begin
        if (rst) sample_q <= $signed({1'b0, RST_MAG});
        else     sample_q <= sample_d;
    end

endmodule

// File: rtl/nco_pm_core.sv
module nco_pm_core
    import nco_pkg::*;
#(
    parameter int ACC_W    = 32,
    parameter int PH_LAT   = 12,
    parameter int DIR_LO_W = 4,
    localparam int DIR_HI_W = PH_W - DIR_LO_W,
    localparam int PIPE_N   = PH_LAT - 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ACC_W-1:0]        freq_word,
    input  logic                    carry_in,
    input  logic                    ph_load,
    input  logic                    ph_sel,
    input  logic [PH_W-1:0]         buf_sin_ph,
    input  logic [PH_W-1:0]         buf_cos_ph,
    input  logic [DIR_HI_W-1:0]     dir_hi,
    input  logic [DIR_LO_W-1:0]     dir_lo,
    output logic [ACC_W-1:0]        acc_out,
    output logic signed [AMP_W-1:0] sin_out,
    output logic signed [AMP_W-1:0] cos_out
);

    localparam sample_t MIN_S = sample_t'(1 << (AMP_W - 1));

    phase_pair_t offs;
    phase_t      acc_top;
    phase_pair_t pipe_q [PIPE_N];
    phase_t      rom_ph [2];
    sample_t     rom_smp [2];

    nco_accum #(.ACC_W(ACC_W)) i_accum (
        .clk       (clk),
        .rst       (rst),
        .freq_word (freq_word),
        .carry_in  (carry_in),
        .acc_q     (acc_out)
    );

    nco_phase_load #(.DIR_LO_W(DIR_LO_W)) i_load (
        .clk        (clk),
        .rst        (rst),
        .ph_load    (ph_load),
        .ph_sel     (ph_sel),
        .buf_sin_ph (buf_sin_ph),
        .buf_cos_ph (buf_cos_ph),
        .dir_hi     (dir_hi),
        .dir_lo     (dir_lo),
        .offs_q     (offs)
    );

    assign acc_top = acc_out[ACC_W-1 -: PH_W];

    // offset adder followed by the latency-matching delay line
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PIPE_N; i++) pipe_q[i] <= '0;
        end else begin
            pipe_q[0].sin_ph <= acc_top + offs.sin_ph;
            pipe_q[0].cos_ph <= acc_top + offs.cos_ph;
            for (int i = 1; i < PIPE_N; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign rom_ph[0] = pipe_q[PIPE_N-1].sin_ph;
    assign rom_ph[1] = pipe_q[PIPE_N-1].cos_ph;

    for (genvar g = 0; g < 2; g++) begin : g_path
        nco_sine_fold #(.QUAD_SHIFT(g == 1)) i_fold (
            .clk      (clk),
            .rst      (rst),
            .phase_in (rom_ph[g]),
            .sample_q (rom_smp[g])
        );
    end

    assign sin_out = rom_smp[0];
    assign cos_out = rom_smp[1];

    // R7: a quarter-turn lead on the sine path makes both samples equal
    a_r7_quadrature: assert property (@(posedge clk) disable iff (rst)
        (rom_ph[0] == rom_ph[1] + phase_t'(QTR_N)) |=> (sin_out == cos_out));

    // R6: the symmetric table never yields the most negative code
    a_r6_no_min_code: assert property (@(posedge clk) disable iff (rst)
        (sin_out != MIN_S) && (cos_out != MIN_S));

endmodule

// File: tb/test_nco_pm_core.sv
`timescale 1ns/1ps
module test_nco_pm_core;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [31:0]        freq_word = '0;
    logic               carry_in = 1'b0;
    logic               ph_load = 1'b0;
    logic               ph_sel = 1'b0;
    logic [11:0]        buf_sin_ph = '0;
    logic [11:0]        buf_cos_ph = '0;
    logic [7:0]         dir_hi = '0;
    logic [3:0]         dir_lo = '0;
    logic [31:0]        acc_out;
    logic signed [11:0] sin_out;
    logic signed [11:0] cos_out;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    nco_pm_core i_nco_pm_core (
        .clk(clk), .rst(rst), .freq_word(freq_word), .carry_in(carry_in),
        .ph_load(ph_load), .ph_sel(ph_sel), .buf_sin_ph(buf_sin_ph),
        .buf_cos_ph(buf_cos_ph), .dir_hi(dir_hi), .dir_lo(dir_lo),
        .acc_out(acc_out), .sin_out(sin_out), .cos_out(cos_out)
    );

    function automatic int s_ref(int p);
        real a;
        a = 6.283185307179586 * (real'(p & 4095) + 0.5) / 4096.0;
        return int'(2047.0 * $sin(a));
    endfunction

    task automatic chk(string tag, longint got, longint exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic chk_near(string tag, int got, int exp);
        n_vec++;
        if (got > exp + 1 || got < exp - 1) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d (+-1)", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; freq_word = '0; carry_in = 1'b0; ph_load = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
    endtask

    task automatic set_src(bit sel, logic [11:0] s, logic [11:0] c);
        ph_sel = sel;
        if (sel) begin
            buf_sin_ph = s; buf_cos_ph = c;
            dir_hi = 8'($urandom); dir_lo = 4'($urandom);
        end else begin
            {dir_hi, dir_lo} = s;
            buf_sin_ph = 12'($urandom); buf_cos_ph = 12'($urandom);
        end
    endtask

    // strobe high for one edge, then low; returns after edge E12
    task automatic load_wait(bit sel, logic [11:0] s, logic [11:0] c);
        ph_load = 1'b1;
        tick();
        ph_load = 1'b0;
        set_src(sel, s, c);
        repeat (13) tick();
    endtask

    initial begin
        logic [11:0] s, c, p;
        logic [31:0] f, exp_acc;
        int rec_s, rec_c;
        void'($urandom(32'd7321));
        do_reset();

        // R3: reset state
        chk("R3 acc cleared", acc_out, 0);
        chk_near("R3 zero-phase sine", sin_out, s_ref(0));
        chk_near("R3 zero-phase cosine", cos_out, s_ref(1024));
        repeat (20) tick();
        chk_near("R3 sine held", sin_out, s_ref(0));
        chk_near("R3 cosine held", cos_out, s_ref(1024));

        // R5 / R6 directed buffer load
        load_wait(1'b1, 12'h400, 12'h000);
        chk_near("R5 buffer sine quarter", sin_out, s_ref(12'h400));
        chk_near("R5 buffer cosine zero", cos_out, s_ref(1024));

        // R5 / R6 random mix of both sources
        for (int i = 0; i < 24; i++) begin
            bit sel;
            sel = 1'($urandom);
            s = 12'($urandom); c = 12'($urandom);
            load_wait(sel, s, c);
            chk_near("R6 sine sample", sin_out, s_ref(s));
            chk_near("R5 cosine source", cos_out, s_ref((sel ? int'(c) : int'(s)) + 1024));
        end

        // R7: quarter-turn lead gives equal samples
        for (int i = 0; i < 6; i++) begin
            c = 12'($urandom);
            load_wait(1'b1, c + 12'd1024, c);
            chk("R7 quadrature equality", int'(sin_out), int'(cos_out));
            chk_near("R7 cosine value", cos_out, s_ref(int'(c) + 1024));
        end

        // R9: offset MSB is a half-turn
        for (int i = 0; i < 4; i++) begin
            p = 12'($urandom);
            load_wait(1'b0, p, 12'h0);
            rec_s = sin_out; rec_c = cos_out;
            load_wait(1'b0, p + 12'd2048, 12'h0);
            chk("R9 sine negated", int'(sin_out), -rec_s);
            chk("R9 cosine negated", int'(cos_out), -rec_c);
        end

        // R8: latency of exactly twelve edges after E0
        load_wait(1'b0, 12'h123, 12'h0);
        ph_load = 1'b1; tick();
        ph_load = 1'b0; set_src(1'b0, 12'h923, 12'h0);
        repeat (12) tick();
        chk_near("R8 old phase through E11", sin_out, s_ref(12'h123));
        tick();
        chk_near("R8 new phase after E12", sin_out, s_ref(12'h923));

        // R4: levels without a fall load nothing
        set_src(1'b0, 12'h5A5, 12'h0);
        repeat (16) tick();
        chk_near("R4 low level ignored", sin_out, s_ref(12'h923));
        ph_load = 1'b1;
        set_src(1'b1, 12'h2B0, 12'h7C0);
        repeat (16) tick();
        chk_near("R4 high level ignored", sin_out, s_ref(12'h923));
        ph_load = 1'b0;
        repeat (13) tick();
        chk_near("R4 release loads sine", sin_out, s_ref(12'h2B0));
        chk_near("R4 release loads cosine", cos_out, s_ref(12'h7C0 + 1024));

        // R4 / R8: commit of one load coincides with detection of the next
        ph_load = 1'b1; tick();
        ph_load = 1'b0; set_src(1'b0, 12'h0C8, 12'h0);
        tick();                              // E0
        ph_load = 1'b1; tick();              // E1 captures first word
        ph_load = 1'b0; tick();              // E2 commit + second fall
        set_src(1'b0, 12'h8C8, 12'h0);
        repeat (10) tick();                  // through E12
        chk_near("R8 back-to-back first", sin_out, s_ref(12'h0C8));
        tick();
        chk_near("R8 back-to-back first held", sin_out, s_ref(12'h0C8));
        tick();
        chk_near("R4 back-to-back second", sin_out, s_ref(12'h8C8));

        // R1: accumulation and wrap
        do_reset();
        freq_word = 32'hC000_0000;
        repeat (3) tick();
        chk("R1 wrap modulo 2^32", acc_out, 32'h4000_0000);
        for (int i = 0; i < 5; i++) begin
            int n;
            bit ci;
            do_reset();
            f = $urandom; ci = 1'($urandom); n = 5 + int'($urandom % 36);
            freq_word = f; carry_in = ci;
            repeat (n) tick();
            exp_acc = 32'(n) * (f + 32'(ci));
            chk(ci ? "R2 accumulate with carry" : "R1 accumulate", acc_out, exp_acc);
        end

        // R2: all-ones step plus carry is a full turn
        do_reset();
        freq_word = 32'hFFFF_FFFF; carry_in = 1'b1;
        repeat (5) tick();
        chk("R2 carry completes full turn", acc_out, 0);
        carry_in = 1'b0;
        repeat (5) tick();
        chk("R2 without carry", acc_out, 32'hFFFF_FFFB);

        // R6: accumulator top bits add to the offset
        do_reset();
        freq_word = 32'h0123_4567;
        repeat (7) tick();
        freq_word = '0;
        exp_acc = 32'd7 * 32'h0123_4567;
        p = 12'($urandom);
        load_wait(1'b0, p, 12'h0);
        chk("R1 frozen accumulator", acc_out, exp_acc);
        chk_near("R6 accumulator plus offset", sin_out, s_ref(int'(exp_acc[31:20] + p)));

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule